// File: doc/BRIEF.md
# Cycle-by-Cycle Half-Bridge Current Fault Detector

This block watches the two current-sense comparator flags of a half-bridge lamp driver and raises a latched fault request for the lamp sequencer. An over-threshold flag, once its enable is on, reports over-current, a lamp that fails to strike, or hard switching. It is checked in every cycle and also cuts the low-side gate through a combinational path in the same cycle, without waiting for a clock edge. An under-threshold flag reports no load or operation below resonance. It is looked at only in the cycle that carries the low-side turn-off strobe, and only while its own enable is on.

The sequencer raises the over-threshold enable once preheat is over, and raises the under-threshold enable in run mode. Any fault that is detected sets a latch. The latch holds until the lamp-removal shutdown path or the supply lockout clears it. A cause register keeps the check that tripped first, which helps with diagnostics.

Top module: `cs_fault_guard`

## Requirements
- R1: After reset, `fault` is 0 and `fault_cause` is 2'b00.
- R2: When `ovr_flag` and `ovr_en` are both 1 in a cycle and no clear is applied, `fault` is 1 after the next rising clock edge.
- R3: When `ovr_en` is 0, `ovr_flag` has no effect on `fault` or on `lo_kill`.
- R4: When `und_flag`, `und_en` and `lo_fall` are all 1 in a cycle and no clear is applied, `fault` is 1 after the next rising edge. If `und_flag` is 0 in the strobe cycle, no fault is set.
- R5: An `und_flag` that arrives in a cycle without `lo_fall` is ignored.
- R6: When `und_en` is 0, `und_flag` is ignored. When both enables are 0, `fault` cannot be set.
- R7: Once set, `fault` and `fault_cause` hold until `clr_sd` or `clr_lock` is 1 at a rising edge. That edge returns them to 0 and 2'b00.
- R8: A clear applied in the same cycle as a set condition wins, and `fault` stays 0.
- R9: `fault_cause` is 2'b01 for the over-threshold check and 2'b10 for the under-threshold check. It is written only when `fault` goes from 0 to 1. If both checks trip in the same cycle, it records 2'b01.
- R10: `lo_kill` is 1 in the same cycle as an enabled over-threshold flag, and whenever `fault` is 1. `lo_out` equals `lo_drv` gated off by `lo_kill`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovr_flag | input | 1 | Sense is above the programmed positive threshold |
| und_flag | input | 1 | Sense is below the negative threshold |
| ovr_en | input | 1 | Enables the over-threshold check (after preheat) |
| und_en | input | 1 | Enables the under-threshold check (run mode) |
| lo_fall | input | 1 | One-cycle strobe at the low-side turn-off edge |
| clr_sd | input | 1 | Clear from shutdown-input cycling |
| clr_lock | input | 1 | Clear from supply lockout |
| lo_drv | input | 1 | Low-side gate request from the oscillator |
| lo_out | output | 1 | Gated low-side drive |
| lo_kill | output | 1 | Combinational low-side kill |
| fault | output | 1 | Latched fault request to the sequencer |
| fault_cause | output | 2 | First tripping check: 01 over, 10 under, 00 none |

## Verification
The assertions take for granted that every input has already been synchronised to `clk`, that `lo_fall` is a single-cycle pulse, and that the clears are levels sampled at the edge. The stimulus changes every input 1 ns after a rising edge and holds it for a whole cycle. Each strobe therefore lasts exactly one clock, and the combinational kill can be read before the next edge.

// File: rtl/cs_fault_guard.sv
module cs_fault_guard (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ovr_flag,
  input  logic       und_flag,
  input  logic       ovr_en,
  input  logic       und_en,
  input  logic       lo_fall,
  input  logic       clr_sd,
  input  logic       clr_lock,
  input  logic       lo_drv,
  output logic       lo_out,
  output logic       lo_kill,
  output logic       fault,
  output logic [1:0] fault_cause
);

  logic clr, ovr_hit, und_hit, set_any;

  assign clr     = clr_sd | clr_lock;
  assign ovr_hit = ovr_en & ovr_flag;
  assign und_hit = und_en & lo_fall & und_flag;
  assign set_any = ovr_hit | und_hit;

  assign lo_kill = ovr_hit | fault;
  assign lo_out  = lo_drv & ~lo_kill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault       <= 1'b0;
      fault_cause <= 2'b00;
    end else if (clr) begin
      fault       <= 1'b0;
      fault_cause <= 2'b00;
    end else if (set_any && !fault) begin
      fault       <= 1'b1;
      fault_cause <= ovr_hit ? 2'b01 : 2'b10;
    end
  end

  assert_ovr_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_en && ovr_flag && !clr_sd && !clr_lock) |=> fault);

  assert_und_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (und_en && lo_fall && und_flag && !clr_sd && !clr_lock) |=> fault);

  assert_no_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault && !lo_fall && !ovr_en) |=> !fault);

  assert_both_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault && !ovr_en && !und_en) |=> !fault);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !clr_sd && !clr_lock) |=> fault);

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_sd || clr_lock) |=> (!fault && fault_cause == 2'b00));

  assert_cause_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $countones(fault_cause) == 1);

  assert_cause_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !clr_sd && !clr_lock) |=> $stable(fault_cause));

  assert_kill_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault || (ovr_en && ovr_flag)) |-> !lo_out);

endmodule

// File: tb/tb_cs_fault_guard.sv
module tb_cs_fault_guard;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ovr_flag = 0, und_flag = 0, ovr_en = 0, und_en = 0, lo_fall = 0;
  logic clr_sd = 0, clr_lock = 0, lo_drv = 0;
  logic lo_out, lo_kill, fault;
  logic [1:0] fault_cause;
  int checks = 0;
  int failures = 0;
  logic exp_prev = 1'b0;

  always #2.5 clk = ~clk;

  cs_fault_guard dut (
    .clk(clk), .rst_n(rst_n), .ovr_flag(ovr_flag), .und_flag(und_flag),
    .ovr_en(ovr_en), .und_en(und_en), .lo_fall(lo_fall), .clr_sd(clr_sd),
    .clr_lock(clr_lock), .lo_drv(lo_drv), .lo_out(lo_out), .lo_kill(lo_kill),
    .fault(fault), .fault_cause(fault_cause)
  );

  // bits: ovr_flag und_flag ovr_en und_en lo_fall clr_sd clr_lock | fault cause[1:0]
  localparam int NV = 14;
  localparam logic [9:0] VEC [NV] = '{
    10'b0000000000,  // R1 idle
    10'b1000000000,  // R3 over flag, disabled
    10'b0101000000,  // R5 under flag, no strobe
    10'b0100100000,  // R6 under flag, under check disabled
    10'b1010000101,  // R2 over trip
    10'b0000000101,  // R7 hold
    10'b0101100101,  // R9 first cause kept
    10'b0000010000,  // R7 shutdown clear
    10'b0101100110,  // R4 under trip
    10'b0000001000,  // R7 lockout clear
    10'b1010010000,  // R8 clear beats set
    10'b1111100101,  // R9 both trip, over wins
    10'b0101111000,  // R8 both clears beat under set
    10'b0001100000   // R4 strobe with sense above threshold
  };
  localparam int REQ [NV] = '{1, 3, 5, 6, 2, 7, 9, 7, 4, 7, 8, 9, 8, 4};

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [6:0] v);
    {ovr_flag, und_flag, ovr_en, und_en, lo_fall, clr_sd, clr_lock} = v;
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    lo_drv = 1'b1;
    #12;
    chk("R1", "fault in reset", int'(fault), 0);
    chk("R1", "cause in reset", int'(fault_cause), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", "fault after reset", int'(fault), 0);
    chk("R10", "lo_out idle", int'(lo_out), 1);

    for (int i = 0; i < NV; i++) begin
      string tag;
      logic ek;
      tag = $sformatf("R%0d", REQ[i]);
      drive(VEC[i][9:3]);
      #1;
      ek = exp_prev | (VEC[i][9] & VEC[i][7]);
      chk(tag, "lo_kill", int'(lo_kill), int'(ek));
      chk(tag, "lo_out", int'(lo_out), int'(!ek));
      @(posedge clk); #1;
      chk(tag, "fault", int'(fault), int'(VEC[i][2]));
      chk(tag, "cause", int'(fault_cause), int'(VEC[i][1:0]));
      exp_prev = VEC[i][2];
    end

    // R10 kill acts within the same cycle, before any edge
    drive(7'b0);
    @(posedge clk); #1;
    ovr_en = 1'b1;
    #1 chk("R10", "lo_out before enable flag", int'(lo_out), 1);
    ovr_flag = 1'b1;
    #0.5 chk("R10", "lo_kill same cycle", int'(lo_kill), 1);
    chk("R10", "lo_out same cycle", int'(lo_out), 0);
    chk("R2", "fault not yet registered", int'(fault), 0);
    @(posedge clk); #1;
    ovr_flag = 1'b0;
    #1 chk("R10", "kill held by latch", int'(lo_kill), 1);

    // R1 reset mid-fault
    rst_n = 1'b0;
    #1 chk("R1", "fault async reset", int'(fault), 0);
    chk("R1", "cause async reset", int'(fault_cause), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    drive(7'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule